// File: doc/BRIEF.md
# ASID-Tagged Sv32 Translation Cache with Selective Fence

The block is a small, fully associative cache of Sv32 address translations. Each slot holds a 20-bit virtual page number, an address-space identifier, a global flag, a megapage flag, a 22-bit physical page number and an opaque permission field. A lookup presents a virtual address and the current address-space identifier. One cycle later the block returns whether a cached translation applied, the 34-bit physical address it produces and the permission bits of the slot that matched.

Translations arrive on a fill port, which a page walker outside the block drives. The cache never observes memory writes, so a stale translation leaves only through the fence port. That port carries an optional page number and an optional address-space identifier, and the pair selects one of four invalidation scopes: everything, one page, one address space, or one page within one address space. Because slots carry the identifier, a context switch needs no flush.

The response path is a three-state machine. RS_QUIET means no response is presented. RS_HIT means a hit is presented. RS_MISS means a miss is presented. On every clock edge the machine moves to RS_HIT if a lookup matched, to RS_MISS if a lookup found nothing, and to RS_QUIET if no lookup was requested. It does so from any state. The fence scope is decoded into FS_ALL, FS_SPACE, FS_PAGE or FS_PAGE_IN_SPACE from the concatenation {fence_use_va, fence_use_asid}, where 00 selects FS_ALL, 01 FS_SPACE, 10 FS_PAGE and 11 FS_PAGE_IN_SPACE.

Top module: `xc_tlb`

## Requirements
- R1: After reset every slot is invalid, rsp_valid and rsp_hit are low, and every lookup misses until a fill arrives.
- R2: A lookup requested in cycle t is answered in cycle t+1: rsp_valid is high exactly in the cycles after a cycle with lk_valid high.
- R3: A valid slot hits when its page matches and either its global flag is set or its identifier equals lk_asid. On a miss, rsp_hit is low and rsp_paddr and rsp_perm are zero.
- R4: A 4 KiB slot compares VPN bits [19:10] against lk_vaddr[31:22] and bits [9:0] against lk_vaddr[21:12], and returns {ppn, lk_vaddr[11:0]}. A megapage slot compares only bits [19:10] and returns {ppn[21:10], lk_vaddr[21:0]}, so ppn[9:0] is ignored.
- R5: A fence with both fence_use_va and fence_use_asid low invalidates every slot.
- R6: A fence with only fence_use_va high invalidates every slot whose page covers fence_vpn, including global slots and slots of any identifier.
- R7: A fence with only fence_use_asid high invalidates the non-global slots whose identifier equals fence_asid. Global slots survive.
- R8: A fence with both flags high invalidates only the non-global slots that match both fence_asid and the page of fence_vpn.
- R9: A fence in the same cycle as a lookup is already visible to that lookup. A fill in the same cycle as a lookup is not visible to it, but is visible to the lookup in the next cycle.
- R10: A fill writes the lowest-numbered invalid slot. If no slot is invalid, it writes the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping at ENTRIES, only on such a replacement. The choice uses the valid bits as they stood before a fence in the same cycle, and the filled slot is valid afterwards even if that fence would have removed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| fill_valid | input | 1 | Write a new translation |
| fill_vpn | input | 20 | Virtual page number of the new translation |
| fill_asid | input | ASID_W | Identifier of the new translation |
| fill_global | input | 1 | New translation applies in every address space |
| fill_mega | input | 1 | New translation is a 4 MiB megapage |
| fill_ppn | input | 22 | Physical page number of the new translation |
| fill_perm | input | PERM_W | Permission bits stored with the translation |
| fence_valid | input | 1 | Invalidate selected translations |
| fence_use_va | input | 1 | Restrict the fence to the page in fence_vpn |
| fence_vpn | input | 20 | Page selector for the fence |
| fence_use_asid | input | 1 | Restrict the fence to fence_asid |
| fence_asid | input | ASID_W | Identifier selector for the fence |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup found a translation |
| rsp_paddr | output | 34 | Translated physical address, zero on a miss |
| rsp_perm | output | PERM_W | Permissions of the matching slot, zero on a miss |

## Verification
A corrupted valid bit or victim pointer cannot be read directly, so it shows up later as a wrong rsp_hit. A slot that wrongly survives a fence returns a stale address on the next lookup of that page. A slot that is wrongly dropped, or a fill written to the wrong slot, makes a later lookup miss where it should hit. The bench therefore compares every response, one cycle after each request, against a behavioural model. It follows each fence and each replacement with lookups of both the pages that were removed and the pages that were kept, so that a fault appears on the very next response.

// File: rtl/xc_pkg.sv
package xc_pkg;
    localparam int VA_W       = 32;
    localparam int PA_W       = 34;
    localparam int OFF_W      = 12;
    localparam int LVL_W      = 10;
    localparam int VPN_W      = 2 * LVL_W;
    localparam int PPN_W      = PA_W - OFF_W;
    localparam int MEGA_OFF_W = OFF_W + LVL_W;

    typedef enum logic [1:0] {
        RS_QUIET = 2'd0,
        RS_HIT   = 2'd1,
        RS_MISS  = 2'd2
    } rsp_state_e;

    // encoding is {use_va, use_asid}
    typedef enum logic [1:0] {
        FS_ALL           = 2'b00,
        FS_SPACE         = 2'b01,
        FS_PAGE          = 2'b10,
        FS_PAGE_IN_SPACE = 2'b11
    } fence_scope_e;
endpackage

// File: rtl/xc_match.sv
module xc_match
    import xc_pkg::*;
#(
    parameter int ASID_W = 9
) (
    input  logic              e_valid,
    input  logic [VPN_W-1:0]  e_vpn,
    input  logic [ASID_W-1:0] e_asid,
    input  logic              e_global,
    input  logic              e_mega,
    input  logic [PPN_W-1:0]  e_ppn,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              fence_valid,
    input  fence_scope_e      fence_scope,
    input  logic [VPN_W-1:0]  fence_vpn,
    input  logic [ASID_W-1:0] fence_asid,
    output logic              kill,
    output logic              hit,
    output logic [PA_W-1:0]   xlat_paddr
);
    // Page compare: a megapage ignores the low VPN level.
    function automatic logic page_eq(input logic [VPN_W-1:0] ev,
                                     input logic             mega,
                                     input logic [VPN_W-1:0] pv);
        logic hi_eq;
        logic lo_eq;
        hi_eq = (ev[VPN_W-1:LVL_W] == pv[VPN_W-1:LVL_W]);
        lo_eq = (ev[LVL_W-1:0] == pv[LVL_W-1:0]);
        return hi_eq && (mega || lo_eq);
    endfunction

    logic fence_page;
    logic fence_space;
    logic lk_page;

    always_comb begin
        fence_page  = page_eq(e_vpn, e_mega, fence_vpn);
        fence_space = !e_global && (e_asid == fence_asid);
        kill        = 1'b0;
        if (fence_valid && e_valid) begin
            unique case (fence_scope)
                FS_ALL:           kill = 1'b1;
                FS_PAGE:          kill = fence_page;
                FS_SPACE:         kill = fence_space;
                FS_PAGE_IN_SPACE: kill = fence_space && fence_page;
            endcase
        end
    end

    always_comb begin
        lk_page = page_eq(e_vpn, e_mega, lk_vaddr[VA_W-1:OFF_W]);
        hit     = e_valid && !kill && lk_page && (e_global || (e_asid == lk_asid));
        if (e_mega)
            xlat_paddr = {e_ppn[PPN_W-1:LVL_W], lk_vaddr[MEGA_OFF_W-1:0]};
        else
            xlat_paddr = {e_ppn, lk_vaddr[OFF_W-1:0]};
    end
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_q,
    input  logic               fill_valid,
    output logic [IDX_W-1:0]   victim
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             have_free;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
        victim = have_free ? free_idx : rr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rr_q <= '0;
        else if (fill_valid && !have_free)
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
endmodule

// File: rtl/xc_resp.sv
module xc_resp
    import xc_pkg::*;
#(
    parameter int PERM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              any_hit,
    input  logic [PA_W-1:0]   hit_paddr,
    input  logic [PERM_W-1:0] hit_perm,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [PERM_W-1:0] rsp_perm
);
    rsp_state_e        state_q;
    rsp_state_e        state_d;
    logic [PA_W-1:0]   pa_q;
    logic [PERM_W-1:0] perm_q;

    always_comb begin
        if (!lk_valid)
            state_d = RS_QUIET;
        else if (any_hit)
            state_d = RS_HIT;
        else
            state_d = RS_MISS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_QUIET;
            pa_q    <= '0;
            perm_q  <= '0;
        end else begin
            state_q <= state_d;
            if (lk_valid && any_hit) begin
                pa_q   <= hit_paddr;
                perm_q <= hit_perm;
            end
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_paddr = '0;
        rsp_perm  = '0;
        unique case (state_q)
            RS_QUIET: ;
            RS_MISS:  rsp_valid = 1'b1;
            RS_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_paddr = pa_q;
                rsp_perm  = perm_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xc_tlb.sv
module xc_tlb
    import xc_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ASID_W  = 9,
    parameter int PERM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [31:0]       lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              fill_valid,
    input  logic [19:0]       fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_global,
    input  logic              fill_mega,
    input  logic [21:0]       fill_ppn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              fence_valid,
    input  logic              fence_use_va,
    input  logic [19:0]       fence_vpn,
    input  logic              fence_use_asid,
    input  logic [ASID_W-1:0] fence_asid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [33:0]       rsp_paddr,
    output logic [PERM_W-1:0] rsp_perm
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q    [ENTRIES];
    logic [ASID_W-1:0]  asid_q   [ENTRIES];
    logic               global_q [ENTRIES];
    logic               mega_q   [ENTRIES];
    logic [PPN_W-1:0]   ppn_q    [ENTRIES];
    logic [PERM_W-1:0]  perm_q   [ENTRIES];

    logic [ENTRIES-1:0] kill_vec;
    logic [ENTRIES-1:0] hit_vec;
    logic [PA_W-1:0]    xlat     [ENTRIES];
    logic [IDX_W-1:0]   victim;
    fence_scope_e       fence_scope;

    logic               any_hit;
    logic [PA_W-1:0]    hit_paddr;
    logic [PERM_W-1:0]  hit_perm;

    assign fence_scope = fence_scope_e'({fence_use_va, fence_use_asid});

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        xc_match #(.ASID_W(ASID_W)) u_match (
            .e_valid     (valid_q[g]),
            .e_vpn       (vpn_q[g]),
            .e_asid      (asid_q[g]),
            .e_global    (global_q[g]),
            .e_mega      (mega_q[g]),
            .e_ppn       (ppn_q[g]),
            .lk_vaddr    (lk_vaddr),
            .lk_asid     (lk_asid),
            .fence_valid (fence_valid),
            .fence_scope (fence_scope),
            .fence_vpn   (fence_vpn),
            .fence_asid  (fence_asid),
            .kill        (kill_vec[g]),
            .hit         (hit_vec[g]),
            .xlat_paddr  (xlat[g])
        );
    end

    // Slots never overlap under correct use, so an OR merge is enough.
    always_comb begin
        any_hit   = |hit_vec;
        hit_paddr = '0;
        hit_perm  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_paddr = hit_paddr | xlat[i];
                hit_perm  = hit_perm  | perm_q[i];
            end
        end
    end

    xc_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_q    (valid_q),
        .fill_valid (fill_valid),
        .victim     (victim)
    );

    // Fence clears first; a fill in the same cycle then claims its slot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_q & ~kill_vec;
            if (fill_valid)
                valid_q[victim] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_valid) begin
            vpn_q[victim]    <= fill_vpn;
            asid_q[victim]   <= fill_asid;
            global_q[victim] <= fill_global;
            mega_q[victim]   <= fill_mega;
            ppn_q[victim]    <= fill_ppn;
            perm_q[victim]   <= fill_perm;
        end
    end

    xc_resp #(.PERM_W(PERM_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .any_hit   (any_hit),
        .hit_paddr (hit_paddr),
        .hit_perm  (hit_perm),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_paddr (rsp_paddr),
        .rsp_perm  (rsp_perm)
    );
endmodule

// File: rtl/xc_tlb_chk.sv
module xc_tlb_chk #(
    parameter int ENTRIES = 8,
    parameter int PERM_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [11:0]        lk_offset,
    input logic               fill_valid,
    input logic               fence_valid,
    input logic               fence_use_va,
    input logic               fence_use_asid,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [33:0]        rsp_paddr,
    input logic [PERM_W-1:0]  rsp_perm,
    input logic [ENTRIES-1:0] valid_q
);
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0 && !rsp_valid)); // R1

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid); // R2

    AST_RSP_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid); // R2

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid); // R3

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && rsp_perm == '0)); // R3

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || rsp_paddr[11:0] == $past(lk_offset))); // R4

    AST_FENCE_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_valid && !fence_use_va && !fence_use_asid && !fill_valid) |=> (valid_q == '0)); // R5

    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (valid_q != '0)); // R10
endmodule

bind xc_tlb xc_tlb_chk #(.ENTRIES(ENTRIES), .PERM_W(PERM_W)) u_xc_tlb_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_valid       (lk_valid),
    .lk_offset      (lk_vaddr[11:0]),
    .fill_valid     (fill_valid),
    .fence_valid    (fence_valid),
    .fence_use_va   (fence_use_va),
    .fence_use_asid (fence_use_asid),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_paddr      (rsp_paddr),
    .rsp_perm       (rsp_perm),
    .valid_q        (valid_q)
);

// File: tb/test_xc_tlb.sv
`timescale 1ns/1ps
module test_xc_tlb;
    localparam int N  = 8;
    localparam int AW = 9;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [31:0]   lk_vaddr = '0;
    logic [AW-1:0] lk_asid = '0;
    logic          fill_valid = 1'b0;
    logic [19:0]   fill_vpn = '0;
    logic [AW-1:0] fill_asid = '0;
    logic          fill_global = 1'b0;
    logic          fill_mega = 1'b0;
    logic [21:0]   fill_ppn = '0;
    logic [PW-1:0] fill_perm = '0;
    logic          fence_valid = 1'b0;
    logic          fence_use_va = 1'b0;
    logic [19:0]   fence_vpn = '0;
    logic          fence_use_asid = 1'b0;
    logic [AW-1:0] fence_asid = '0;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [33:0]   rsp_paddr;
    logic [PW-1:0] rsp_perm;

    always #2.5 clk = ~clk;

    xc_tlb #(.ENTRIES(N), .ASID_W(AW), .PERM_W(PW)) i_xc_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_global(fill_global), .fill_mega(fill_mega), .fill_ppn(fill_ppn),
        .fill_perm(fill_perm),
        .fence_valid(fence_valid), .fence_use_va(fence_use_va), .fence_vpn(fence_vpn),
        .fence_use_asid(fence_use_asid), .fence_asid(fence_asid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural model state
    bit            m_v    [N];
    logic [19:0]   m_vpn  [N];
    logic [AW-1:0] m_asid [N];
    bit            m_g    [N];
    bit            m_mega [N];
    logic [21:0]   m_ppn  [N];
    logic [PW-1:0] m_perm [N];
    int            m_rr = 0;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit covers(int i, logic [19:0] vpn);
        if (m_vpn[i][19:10] != vpn[19:10]) return 1'b0;
        return m_mega[i] || (m_vpn[i][9:0] == vpn[9:0]);
    endfunction

    // One clock: predict from model and present inputs, advance model, compare.
    task automatic step(input string tag);
        bit            kill [N];
        bit            e_valid;
        bit            e_hit;
        logic [33:0]   e_pa;
        logic [PW-1:0] e_perm;
        int            vic;
        for (int i = 0; i < N; i++) begin
            kill[i] = 1'b0;
            if (fence_valid && m_v[i]) begin
                if (!fence_use_va && !fence_use_asid)
                    kill[i] = 1'b1;
                else if (fence_use_va && !fence_use_asid)
                    kill[i] = covers(i, fence_vpn);
                else if (!fence_use_va)
                    kill[i] = !m_g[i] && (m_asid[i] == fence_asid);
                else
                    kill[i] = !m_g[i] && (m_asid[i] == fence_asid) && covers(i, fence_vpn);
            end
        end
        e_valid = lk_valid;
        e_hit   = 1'b0;
        e_pa    = '0;
        e_perm  = '0;
        if (lk_valid) begin
            for (int i = 0; i < N; i++) begin
                if (m_v[i] && !kill[i] && covers(i, lk_vaddr[31:12]) &&
                    (m_g[i] || m_asid[i] == lk_asid)) begin
                    e_hit  = 1'b1;
                    e_pa   = m_mega[i] ? {m_ppn[i][21:10], lk_vaddr[21:0]}
                                       : {m_ppn[i], lk_vaddr[11:0]};
                    e_perm = m_perm[i];
                end
            end
        end
        vic = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vic = i;
        for (int i = 0; i < N; i++) if (kill[i]) m_v[i] = 1'b0;
        if (fill_valid) begin
            if (vic < 0) begin
                vic  = m_rr;
                m_rr = (m_rr + 1) % N;
            end
            m_v[vic]    = 1'b1;
            m_vpn[vic]  = fill_vpn;
            m_asid[vic] = fill_asid;
            m_g[vic]    = fill_global;
            m_mega[vic] = fill_mega;
            m_ppn[vic]  = fill_ppn;
            m_perm[vic] = fill_perm;
        end
        @(posedge clk);
        @(negedge clk);
        lk_valid    = 1'b0;
        fill_valid  = 1'b0;
        fence_valid = 1'b0;
        check(tag, "rsp_valid", 64'(rsp_valid), 64'(e_valid));
        check(tag, "rsp_hit",   64'(rsp_hit),   64'(e_hit));
        check(tag, "rsp_paddr", 64'(rsp_paddr), 64'(e_pa));
        check(tag, "rsp_perm",  64'(rsp_perm),  64'(e_perm));
    endtask

    task automatic set_lk(input logic [31:0] va, input logic [AW-1:0] asid);
        lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid;
    endtask

    task automatic set_fill(input logic [19:0] vpn, input logic [AW-1:0] asid,
                            input bit g, input bit mega, input logic [21:0] ppn,
                            input logic [PW-1:0] perm);
        fill_valid = 1'b1; fill_vpn = vpn; fill_asid = asid;
        fill_global = g; fill_mega = mega; fill_ppn = ppn; fill_perm = perm;
    endtask

    task automatic set_fence(input bit use_va, input logic [19:0] vpn,
                             input bit use_asid, input logic [AW-1:0] asid);
        fence_valid = 1'b1; fence_use_va = use_va; fence_vpn = vpn;
        fence_use_asid = use_asid; fence_asid = asid;
    endtask

    task automatic look(input logic [31:0] va, input logic [AW-1:0] asid, input string tag);
        set_lk(va, asid);
        step(tag);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        check("R1", "rsp_hit in reset",   64'(rsp_hit),   64'd0);
        rst_n = 1'b1;
        step("R1");
        look(32'h0000_0000, 9'd0, "R1");
        look(32'h1234_5678, 9'd3, "R1");

        // 4 KiB slot, identifier 5
        set_fill(20'h00401, 9'd5, 1'b0, 1'b0, 22'h2ABCD, 4'hB); step("R10");
        look(32'h0040_1ABC, 9'd5, "R3");
        look(32'h0040_1ABC, 9'd6, "R3");
        look(32'h0040_2ABC, 9'd5, "R4");
        set_lk(32'h0040_1FFF, 9'd5); step("R2");
        step("R2");

        // global megapage, low ppn bits nonzero
        set_fill({10'h003, 10'h000}, 9'd7, 1'b1, 1'b1, 22'h3C0155, 4'h6); step("R10");
        look({10'h003, 22'h2A5F3}, 9'd1, "R4");
        look({10'h003, 22'h0000A}, 9'd9, "R3");
        look({10'h004, 22'h0000A}, 9'd7, "R4");

        // fill the rest, identifier 2
        for (int k = 0; k < 6; k++) begin
            set_fill({10'(8 + k), 10'(k)}, 9'd2, 1'b0, 1'b0, 22'(22'h100 + k), 4'(k));
            step("R10");
        end
        look({10'd10, 10'd2, 12'h345}, 9'd2, "R10");
        // replacements by round robin: slots 0 then 1
        set_fill(20'hABCDE, 9'd3, 1'b1, 1'b0, 22'h011111, 4'h1); step("R10");
        set_fill(20'h12345, 9'd3, 1'b0, 1'b0, 22'h022222, 4'h2); step("R10");
        look(32'h0040_1ABC, 9'd5, "R10");
        look({10'h003, 22'h0}, 9'd7, "R10");
        look(32'hABCD_E010, 9'd8, "R10");
        look(32'h1234_5020, 9'd3, "R10");

        // identifier-only fence
        set_fence(1'b0, 20'h0, 1'b1, 9'd2); step("R7");
        look({10'd10, 10'd2, 12'h345}, 9'd2, "R7");
        look({10'd13, 10'd5, 12'h000}, 9'd2, "R7");
        look(32'hABCD_E010, 9'd2, "R7");
        set_fence(1'b0, 20'h0, 1'b1, 9'd3); step("R7");
        look(32'hABCD_E010, 9'd3, "R7");
        look(32'h1234_5020, 9'd3, "R7");

        // page-only fence removes a global slot
        set_fence(1'b1, 20'hABCDE, 1'b0, 9'd0); step("R6");
        look(32'hABCD_E010, 9'd3, "R6");

        // page-within-space fence
        set_fill(20'h55555, 9'd3, 1'b0, 1'b0, 22'h033333, 4'h3); step("R10");
        set_fill(20'h55555, 9'd4, 1'b0, 1'b0, 22'h044444, 4'h4); step("R10");
        set_fill(20'h66666, 9'd3, 1'b1, 1'b0, 22'h055555, 4'h5); step("R10");
        set_fence(1'b1, 20'h55555, 1'b1, 9'd3); step("R8");
        look(32'h5555_5001, 9'd3, "R8");
        look(32'h5555_5001, 9'd4, "R8");
        set_fence(1'b1, 20'h66666, 1'b1, 9'd3); step("R8");
        look(32'h6666_6002, 9'd3, "R8");

        // same-cycle fill and lookup, fence and lookup
        set_fill(20'h77777, 9'd1, 1'b0, 1'b0, 22'h066666, 4'h7);
        set_lk(32'h7777_7003, 9'd1); step("R9");
        look(32'h7777_7003, 9'd1, "R9");
        set_fence(1'b1, 20'h77777, 1'b0, 9'd0);
        set_lk(32'h7777_7003, 9'd1); step("R9");
        set_fence(1'b0, 20'h0, 1'b0, 9'd0);
        set_lk(32'h5555_5001, 9'd4); step("R9");
        look(32'h6666_6002, 9'd3, "R5");

        // refill fully, then fence-all with a fill in the same cycle
        for (int k = 0; k < N; k++) begin
            set_fill({10'(40 + k), 10'(k)}, 9'd6, 1'b0, 1'b0, 22'(22'h200 + k), 4'(k));
            step("R10");
        end
        set_fill(20'hFEDCB, 9'd6, 1'b0, 1'b0, 22'h0ABCDE, 4'hE);
        set_fence(1'b0, 20'h0, 1'b0, 9'd0); step("R10");
        look(32'hFEDC_B777, 9'd6, "R10");
        look({10'd40, 10'd0, 12'h0}, 9'd6, "R5");
        look({10'd47, 10'd7, 12'h0}, 9'd6, "R5");
        set_fill(20'h0F0F0, 9'd6, 1'b0, 1'b1, 22'h3FFFFF, 4'h9); step("R10");
        look(32'h0F3F_FFFF, 9'd6, "R4");
        look(32'hFEDC_B000, 9'd6, "R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule